// File: doc/BRIEF.md
# Set/Clear Peripheral Reset and Clock-Stop Register Bank

This block keeps two wide control vectors for a group of peripherals: one bit per peripheral reset line and one bit per peripheral clock-stop control. Each vector is split into 32-bit words. Every word can be reached at two addresses. A write to the first address turns on the bits that are one in the written data. A write to the second address, four bytes higher, turns those bits off. Bits that are zero in the data stay as they are in both cases, so software can change one peripheral without a read-modify-write.

The stored reset bits drive the peripheral reset lines directly. The stored clock-stop bits become per-peripheral clock enables, and a stored one stops the clock. One configurable index works the other way round: for that index a stored one means the clock runs. Two reference-clock divide selects for UART references are also driven from the bank. The auxiliary one is the top bit of the first clock-stop word. The primary one is a single bit in a separate miscellaneous word that uses the same set/clear pair. Access goes through a simple single-cycle register bus. A write takes effect at the next clock edge, and read data is combinational from the address.

Top module: `scr_bank`

## Requirements
- R1: After reset every line of `periph_rst` is 1, `periph_clk_en` equals the critical mask (default 64'h0000_0004_8000_0061), and both divide selects are 0.
- R2: A write to a set address (reset words 0x040/0x050, clock words 0x080/0x090, misc 0x0C0) sets the stored bits that are one in `bus_wdata` and leaves all other bits unchanged.
- R3: A write to a clear address (set address + 0x4) clears the stored bits that are one in `bus_wdata` and leaves all other bits unchanged.
- R4: Peripheral index i is bit (i mod 32) of the low word (0x040 / 0x080) when i < 32 and of the high word (0x050 / 0x090) when i >= 32.
- R5: `periph_clk_en[i]` is the inverse of stored clock-stop bit i for every index except index 14, where it equals the stored bit.
- R6: A read of either the set or the clear address of a word returns that word's stored value. The misc word reads as bit 12 only, and any unmapped address reads 0.
- R7: A write to an unmapped address (for example 0x000, 0x048, 0x0C8) changes no output and no stored word.
- R8: `uart_aux_div13` equals stored bit 31 of the clock word at 0x080, and `uart_pri_div13` equals stored bit 12 of the misc word at 0x0C0.
- R9: State changes only at a clock edge where `bus_wr` is 1. With `bus_wr` at 0, all outputs hold whatever the address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write mask data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| periph_rst | output | 64 | Per-peripheral reset, 1 = held in reset |
| periph_clk_en | output | 64 | Per-peripheral clock enable, 1 = running |
| uart_pri_div13 | output | 1 | Primary UART reference divide-by-13 select |
| uart_aux_div13 | output | 1 | Auxiliary UART reference divide-by-13 select |

## Verification
The assertions check on every cycle that outputs hold when no write is strobed, that a set or clear write on the low reset word has its masked effect one edge later, and that the clock enables and the auxiliary divide select agree with what the bus reads back from the first clock word, including the inverted index. The bench scenarios cover what a cycle-local property cannot show: the reset image of all four words, how indices map into the high words, clear-alias reads, unmapped writes that leave everything untouched, and the misc word's single live bit.

// File: rtl/scr_pkg.sv
package scr_pkg;
   localparam int unsigned WORD_W        = 32;
   localparam int unsigned DEF_LINES     = 64;
   localparam int unsigned DEF_ADDR_W    = 12;
   localparam int unsigned DEF_RST_BASE  = 'h040;
   localparam int unsigned DEF_CLK_BASE  = 'h080;
   localparam int unsigned DEF_MISC_BASE = 'h0C0;
   localparam int unsigned WORD_STRIDE   = 'h010;
   localparam int unsigned CLR_OFFSET    = 'h004;
   localparam int unsigned DEF_INV_IDX   = 14;
   localparam int unsigned DEF_PRI_BIT   = 12;
   localparam int unsigned DEF_AUX_BIT   = 31;
   localparam logic [DEF_LINES-1:0] DEF_CRIT_MASK = 64'h0000_0004_8000_0061;

   // stored clock-stop image that gives "running" exactly on run_mask
   function automatic logic [DEF_LINES-1:0] stop_image(input logic [DEF_LINES-1:0] run_mask,
                                                       input int unsigned inv_idx);
      logic [DEF_LINES-1:0] img;
      img = ~run_mask;
      img[inv_idx] = run_mask[inv_idx];
      return img;
   endfunction
endpackage

// File: rtl/scr_word.sv
module scr_word #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_stb,
   input  logic         clr_stb,
   input  logic [W-1:0] mask,
   output logic [W-1:0] q
);
   logic [W-1:0] set_bits;
   logic [W-1:0] clr_bits;

   always_comb begin
      set_bits = set_stb ? mask : '0;
      clr_bits = clr_stb ? mask : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else if (set_stb || clr_stb) q <= (q | set_bits) & ~clr_bits;
   end
endmodule

// File: rtl/scr_decode.sv
module scr_decode #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NUM_WORDS = 2,
   parameter int unsigned RST_BASE  = 'h040,
   parameter int unsigned CLK_BASE  = 'h080,
   parameter int unsigned MISC_BASE = 'h0C0,
   parameter int unsigned STRIDE    = 'h010,
   parameter int unsigned CLR_OFS   = 'h004
) (
   input  logic                 wr,
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_WORDS-1:0] rst_set,
   output logic [NUM_WORDS-1:0] rst_clr,
   output logic [NUM_WORDS-1:0] clk_set,
   output logic [NUM_WORDS-1:0] clk_clr,
   output logic                 misc_set,
   output logic                 misc_clr,
   output logic [NUM_WORDS-1:0] rd_rst,
   output logic [NUM_WORDS-1:0] rd_clk,
   output logic                 rd_misc
);
   for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
      localparam logic [ADDR_W-1:0] RS = ADDR_W'(RST_BASE + k * STRIDE);
      localparam logic [ADDR_W-1:0] RC = ADDR_W'(RST_BASE + k * STRIDE + CLR_OFS);
      localparam logic [ADDR_W-1:0] CS = ADDR_W'(CLK_BASE + k * STRIDE);
      localparam logic [ADDR_W-1:0] CC = ADDR_W'(CLK_BASE + k * STRIDE + CLR_OFS);
      logic hit_rs, hit_rc, hit_cs, hit_cc;
      always_comb begin
         hit_rs     = (addr == RS);
         hit_rc     = (addr == RC);
         hit_cs     = (addr == CS);
         hit_cc     = (addr == CC);
         rst_set[k] = wr && hit_rs;
         rst_clr[k] = wr && hit_rc;
         clk_set[k] = wr && hit_cs;
         clk_clr[k] = wr && hit_cc;
         rd_rst[k]  = hit_rs || hit_rc;
         rd_clk[k]  = hit_cs || hit_cc;
      end
   end

   localparam logic [ADDR_W-1:0] MS = ADDR_W'(MISC_BASE);
   localparam logic [ADDR_W-1:0] MC = ADDR_W'(MISC_BASE + CLR_OFS);

   always_comb begin
      misc_set = wr && (addr == MS);
      misc_clr = wr && (addr == MC);
      rd_misc  = (addr == MS) || (addr == MC);
   end
endmodule

// File: rtl/scr_clk_polarity.sv
module scr_clk_polarity #(
   parameter int unsigned N       = 64,
   parameter int unsigned INV_IDX = 14
) (
   input  logic [N-1:0] stop_bits,
   output logic [N-1:0] clk_en
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      if (i == INV_IDX) begin : g_active_high
         assign clk_en[i] = stop_bits[i];
      end else begin : g_active_low
         assign clk_en[i] = ~stop_bits[i];
      end
   end
endmodule

// File: rtl/scr_bank.sv
module scr_bank
   import scr_pkg::*;
#(
   parameter int unsigned NUM_LINES = DEF_LINES,
   parameter int unsigned ADDR_W    = DEF_ADDR_W,
   parameter int unsigned RST_BASE  = DEF_RST_BASE,
   parameter int unsigned CLK_BASE  = DEF_CLK_BASE,
   parameter int unsigned MISC_BASE = DEF_MISC_BASE,
   parameter int unsigned INV_IDX   = DEF_INV_IDX,
   parameter int unsigned PRI_BIT   = DEF_PRI_BIT,
   parameter int unsigned AUX_BIT   = DEF_AUX_BIT,
   parameter logic [NUM_LINES-1:0] CRIT_MASK = DEF_CRIT_MASK
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [WORD_W-1:0]    bus_wdata,
   output logic [WORD_W-1:0]    bus_rdata,
   output logic [NUM_LINES-1:0] periph_rst,
   output logic [NUM_LINES-1:0] periph_clk_en,
   output logic                 uart_pri_div13,
   output logic                 uart_aux_div13
);
   localparam int unsigned NUM_WORDS = NUM_LINES / WORD_W;
   localparam logic [NUM_LINES-1:0] STOP_RST = NUM_LINES'(stop_image(DEF_LINES'(CRIT_MASK), INV_IDX));

   if (NUM_LINES % WORD_W != 0 || NUM_LINES == 0) begin : g_bad_lines
      $error("NUM_LINES must be a non-zero multiple of the word width");
   end
   if (INV_IDX >= NUM_LINES || AUX_BIT >= WORD_W || PRI_BIT >= WORD_W) begin : g_bad_index
      $error("bit index parameter out of range");
   end
   if (NUM_LINES > DEF_LINES) begin : g_bad_size
      $error("NUM_LINES exceeds the package image width");
   end
   if ((1 << ADDR_W) <= MISC_BASE + CLR_OFFSET) begin : g_bad_addr
      $error("ADDR_W too narrow for the register offsets");
   end

   logic [NUM_WORDS-1:0] rst_set, rst_clr, clk_set, clk_clr;
   logic [NUM_WORDS-1:0] rd_rst, rd_clk;
   logic                 misc_set, misc_clr, rd_misc;
   logic [NUM_LINES-1:0] stop_q;
   logic [0:0]           misc_q;

   scr_decode #(
      .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .RST_BASE(RST_BASE),
      .CLK_BASE(CLK_BASE), .MISC_BASE(MISC_BASE), .STRIDE(WORD_STRIDE),
      .CLR_OFS(CLR_OFFSET)
   ) u_dec (
      .wr(bus_wr), .addr(bus_addr),
      .rst_set(rst_set), .rst_clr(rst_clr), .clk_set(clk_set), .clk_clr(clk_clr),
      .misc_set(misc_set), .misc_clr(misc_clr),
      .rd_rst(rd_rst), .rd_clk(rd_clk), .rd_misc(rd_misc)
   );

   for (genvar k = 0; k < NUM_WORDS; k++) begin : g_words
      scr_word #(.W(WORD_W), .RST_VAL({WORD_W{1'b1}})) u_rst (
         .clk(clk), .rst_n(rst_n), .set_stb(rst_set[k]), .clr_stb(rst_clr[k]),
         .mask(bus_wdata), .q(periph_rst[k*WORD_W +: WORD_W])
      );
      scr_word #(.W(WORD_W), .RST_VAL(STOP_RST[k*WORD_W +: WORD_W])) u_stop (
         .clk(clk), .rst_n(rst_n), .set_stb(clk_set[k]), .clr_stb(clk_clr[k]),
         .mask(bus_wdata), .q(stop_q[k*WORD_W +: WORD_W])
      );
   end

   scr_word #(.W(1), .RST_VAL(1'b0)) u_misc (
      .clk(clk), .rst_n(rst_n), .set_stb(misc_set), .clr_stb(misc_clr),
      .mask(bus_wdata[PRI_BIT]), .q(misc_q)
   );

   scr_clk_polarity #(.N(NUM_LINES), .INV_IDX(INV_IDX)) u_pol (
      .stop_bits(stop_q), .clk_en(periph_clk_en)
   );

   always_comb begin
      bus_rdata = '0;
      for (int k = 0; k < NUM_WORDS; k++) begin
         if (rd_rst[k]) bus_rdata = bus_rdata | periph_rst[k*WORD_W +: WORD_W];
         if (rd_clk[k]) bus_rdata = bus_rdata | stop_q[k*WORD_W +: WORD_W];
      end
      if (rd_misc) bus_rdata[PRI_BIT] = misc_q[0];
   end

   assign uart_pri_div13 = misc_q[0];
   assign uart_aux_div13 = stop_q[AUX_BIT];
endmodule

// File: rtl/scr_bank_chk.sv
module scr_bank_chk
   import scr_pkg::*;
(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_wr,
   input logic [DEF_ADDR_W-1:0] bus_addr,
   input logic [WORD_W-1:0]     bus_wdata,
   input logic [WORD_W-1:0]     bus_rdata,
   input logic [DEF_LINES-1:0]  periph_rst,
   input logic [DEF_LINES-1:0]  periph_clk_en,
   input logic                  uart_pri_div13,
   input logic                  uart_aux_div13
);
   localparam logic [DEF_ADDR_W-1:0] A_RS = DEF_ADDR_W'(DEF_RST_BASE);
   localparam logic [DEF_ADDR_W-1:0] A_RC = DEF_ADDR_W'(DEF_RST_BASE + CLR_OFFSET);
   localparam logic [DEF_ADDR_W-1:0] A_CS = DEF_ADDR_W'(DEF_CLK_BASE);

   a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(periph_rst) && $stable(periph_clk_en) &&
                  $stable(uart_pri_div13) && $stable(uart_aux_div13));

   a_r2_set_low_reset: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == A_RS |=> (periph_rst[31:0] & $past(bus_wdata)) == $past(bus_wdata));

   a_r3_clear_low_reset: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == A_RC |=> (periph_rst[31:0] & $past(bus_wdata)) == '0);

   a_r5_inverted_index: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == A_CS |-> bus_rdata[DEF_INV_IDX] == periph_clk_en[DEF_INV_IDX]);

   a_r5_normal_index: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == A_CS |-> bus_rdata[0] == !periph_clk_en[0] && bus_rdata[13] == !periph_clk_en[13]);

   a_r8_aux_select: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == A_CS |-> uart_aux_div13 == bus_rdata[DEF_AUX_BIT]);
endmodule

bind scr_bank scr_bank_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_rst(periph_rst),
   .periph_clk_en(periph_clk_en), .uart_pri_div13(uart_pri_div13),
   .uart_aux_div13(uart_aux_div13)
);

// File: tb/scr_bank_tb.sv
module scr_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = 12'hFF0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] periph_rst;
   logic [63:0] periph_clk_en;
   logic        uart_pri_div13;
   logic        uart_aux_div13;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   scr_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_rst(periph_rst),
      .periph_clk_en(periph_clk_en), .uart_pri_div13(uart_pri_div13),
      .uart_aux_div13(uart_aux_div13)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 12'hFF0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] r;
      check("R1 reset lines", periph_rst, 64'hFFFF_FFFF_FFFF_FFFF);
      check("R1 clock enables", periph_clk_en, 64'h0000_0004_8000_0061);
      check("R1 divide selects", {uart_pri_div13, uart_aux_div13}, 0);
      bus_read(12'h080, r); check("R4 low clock word image", r, 32'h7FFF_BF9E);
      bus_read(12'h090, r); check("R4 high clock word image", r, 32'hFFFF_FFFB);
   endtask

   task automatic t_reset_words;
      logic [31:0] r;
      bus_write(12'h044, 32'h0000_00F0);
      check("R3 clear low reset", periph_rst[31:0], 32'hFFFF_FF0F);
      bus_write(12'h040, 32'h0000_0010);
      check("R2 set low reset", periph_rst[31:0], 32'hFFFF_FF1F);
      bus_read(12'h044, r); check("R6 clear alias read", r, 32'hFFFF_FF1F);
      bus_read(12'h040, r); check("R6 set address read", r, 32'hFFFF_FF1F);
      bus_write(12'h054, 32'h0000_0001);
      check("R4 index 32 in high word", periph_rst, 64'hFFFF_FFFE_FFFF_FF1F);
      bus_read(12'h050, r); check("R4 high reset read", r, 32'hFFFF_FFFE);
   endtask

   task automatic t_clock_words;
      bus_write(12'h084, 32'h0000_0008);
      check("R5 clear stop runs clock", periph_clk_en, 64'h0000_0004_8000_0069);
      bus_write(12'h080, 32'h0000_4000);
      check("R5 set inverted index enables", periph_clk_en, 64'h0000_0004_8000_4069);
      bus_write(12'h084, 32'h0000_4000);
      check("R5 clear inverted index stops", periph_clk_en, 64'h0000_0004_8000_0069);
      bus_write(12'h080, 32'h0000_0001);
      check("R2 set stop on index 0", periph_clk_en, 64'h0000_0004_8000_0068);
      bus_write(12'h090, 32'h0000_0004);
      check("R4 index 34 high clock word", periph_clk_en, 64'h0000_0000_8000_0068);
   endtask

   task automatic t_divide;
      logic [31:0] r;
      bus_write(12'h080, 32'h8000_0000);
      check("R8 aux select on", {periph_clk_en[31], uart_aux_div13}, 2'b01);
      bus_write(12'h084, 32'h8000_0000);
      check("R8 aux select off", uart_aux_div13, 0);
      bus_write(12'h0C0, 32'hFFFF_FFFF);
      check("R8 primary select on", uart_pri_div13, 1);
      bus_read(12'h0C4, r); check("R6 misc reads bit 12 only", r, 32'h0000_1000);
      bus_write(12'h0C4, 32'h0000_1000);
      check("R3 primary select cleared", uart_pri_div13, 0);
   endtask

   task automatic t_unmapped;
      logic [31:0] r;
      logic [63:0] rs, ce;
      rs = periph_rst; ce = periph_clk_en;
      bus_write(12'h048, 32'hFFFF_FFFF);
      bus_write(12'h000, 32'hFFFF_FFFF);
      bus_write(12'h0C8, 32'hFFFF_FFFF);
      check("R7 reset lines untouched", periph_rst, rs);
      check("R7 clock enables untouched", periph_clk_en, ce);
      check("R7 divide selects untouched", {uart_pri_div13, uart_aux_div13}, 0);
      bus_read(12'h048, r); check("R6 unmapped reads zero", r, 0);
   endtask

   task automatic t_no_write;
      logic [63:0] rs, ce;
      rs = periph_rst; ce = periph_clk_en;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 12'h044; bus_wdata = 32'hFFFF_FFFF;
      repeat (4) @(negedge clk);
      bus_addr = 12'h080;
      repeat (4) @(negedge clk);
      check("R9 reset held without strobe", periph_rst, rs);
      check("R9 enables held without strobe", periph_clk_en, ce);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reset_words();
      t_clock_words();
      t_divide();
      t_unmapped();
      t_no_write();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule